// File: doc/BRIEF.md
# Masked Bit Test and Update Unit

This unit carries out the execute step of a family of bit-test instructions on a 36-bit word machine. It forms a mask from one of four sources, tests the working register against that mask, and may rewrite the masked register bits. It also decides whether the following instruction should be skipped. The caller supplies the register contents, the memory operand, the effective address and three small select fields, and pulses a valid strobe.

One clock later the unit returns the updated register value, a write enable for the register file and a skip flag. The skip decision always looks at the register as it was before the update. This means a single instruction can both test a set of bits and change them. Operand fetch and program-counter advance belong to neighbouring logic.

Top module: `mask_test_unit`

## Requirements
- R1: While reset is asserted (rst_n low), and on the first edge after it, out_valid, reg_we, skip_out and new_reg are all zero.
- R2: mask_sel selects the mask. 0 gives the effective address in the low half with the high half zero. 1 gives the effective address in the high half with the low half zero. 2 gives the memory word. 3 gives the memory word with its two 18-bit halves exchanged.
- R3: act_sel 0 leaves the register as it is: new_reg equals reg_val and reg_we is low.
- R4: act_sel 1 clears every register bit where the mask is one and keeps the other bits; reg_we is high.
- R5: act_sel 2 inverts every register bit where the mask is one and keeps the other bits; reg_we is high.
- R6: act_sel 3 sets every register bit where the mask is one and keeps the other bits; reg_we is high.
- R7: skip_sel 0 never skips and skip_sel 1 always skips.
- R8: skip_sel 2 skips when the AND of the unmodified reg_val and the mask is zero. skip_sel 3 skips when that AND is nonzero. The register update does not affect the decision.
- R9: A request accepted on an edge with in_valid high shows its results on the outputs right after that edge, with out_valid high for exactly that one cycle.
- R10: After an edge with in_valid low, out_valid, reg_we and skip_out are low, and new_reg keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| reg_val | input | 36 | Register contents before the instruction |
| mem_val | input | 36 | Memory operand word |
| eff_addr | input | 18 | Effective address |
| mask_sel | input | 2 | Mask source select |
| act_sel | input | 2 | Bit update select |
| skip_sel | input | 2 | Skip condition select |
| out_valid | output | 1 | Result strobe |
| new_reg | output | 36 | Updated register value |
| reg_we | output | 1 | Register write enable |
| skip_out | output | 1 | Skip the next instruction |

## Verification
Directed cases use a one-hot memory word and an asymmetric memory word under all four mask sources. A swapped or misplaced half then shows up as a bit in the wrong position. Registers that are all zero, all one, or alternating patterns are paired with each update action. The update changes the tested bits in these cases, so a skip decision taken after the update would flip and be caught. Seeded random requests with idle gaps between them cover all 64 select combinations, and check that the result is held and the strobes drop between requests.

// File: rtl/mtu_pkg.sv
package mtu_pkg;

   typedef enum logic [1:0] {
      MSRC_ADDR_LO  = 2'd0,
      MSRC_ADDR_HI  = 2'd1,
      MSRC_MEM      = 2'd2,
      MSRC_MEM_SWAP = 2'd3
   } msrc_e;

   typedef enum logic [1:0] {
      ACT_KEEP  = 2'd0,
      ACT_CLEAR = 2'd1,
      ACT_FLIP  = 2'd2,
      ACT_SET   = 2'd3
   } act_e;

   typedef enum logic [1:0] {
      SKP_NEVER  = 2'd0,
      SKP_ALWAYS = 2'd1,
      SKP_ZERO   = 2'd2,
      SKP_ANY    = 2'd3
   } skip_e;

   // Result of one masked bit under a given action
   function automatic logic masked_bit(input act_e act, input logic b);
      case (act)
         ACT_CLEAR: masked_bit = 1'b0;
         ACT_FLIP:  masked_bit = ~b;
         ACT_SET:   masked_bit = 1'b1;
         default:   masked_bit = b;
      endcase
   endfunction

endpackage

// File: rtl/mtu_mask_gen.sv
module mtu_mask_gen
   import mtu_pkg::*;
#(
   parameter int WORD_W = 36,
   localparam int HALF_W = WORD_W / 2
) (
   input  logic [HALF_W-1:0] addr,
   input  logic [WORD_W-1:0] mem,
   input  msrc_e             sel,
   output logic [WORD_W-1:0] mask
);

   logic [HALF_W-1:0] mem_hi;
   logic [HALF_W-1:0] mem_lo;

   assign mem_hi = mem[WORD_W-1:HALF_W];
   assign mem_lo = mem[HALF_W-1:0];

   always_comb begin
      case (sel)
         MSRC_ADDR_LO:  mask = {{HALF_W{1'b0}}, addr};
         MSRC_ADDR_HI:  mask = {addr, {HALF_W{1'b0}}};
         MSRC_MEM:      mask = mem;
         MSRC_MEM_SWAP: mask = {mem_lo, mem_hi};
         default:       mask = '0;
      endcase
   end

endmodule

// File: rtl/mtu_bit_update.sv
module mtu_bit_update
   import mtu_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input  logic [WORD_W-1:0] reg_in,
   input  logic [WORD_W-1:0] mask,
   input  act_e              act,
   output logic [WORD_W-1:0] reg_out,
   output logic              we
);

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      assign reg_out[i] = mask[i] ? masked_bit(act, reg_in[i]) : reg_in[i];
   end

   assign we = (act != ACT_KEEP);

endmodule

// File: rtl/mtu_skip_eval.sv
module mtu_skip_eval
   import mtu_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input  logic [WORD_W-1:0] reg_in,
   input  logic [WORD_W-1:0] mask,
   input  skip_e             cond,
   output logic              skip
);

   logic any_hit;

   assign any_hit = |(reg_in & mask);

   always_comb begin
      case (cond)
         SKP_NEVER:  skip = 1'b0;
         SKP_ALWAYS: skip = 1'b1;
         SKP_ZERO:   skip = ~any_hit;
         SKP_ANY:    skip = any_hit;
         default:    skip = 1'b0;
      endcase
   end

endmodule

// File: rtl/mask_test_unit.sv
module mask_test_unit
   import mtu_pkg::*;
#(
   parameter int WORD_W = 36,
   localparam int HALF_W = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] reg_val,
   input  logic [WORD_W-1:0] mem_val,
   input  logic [HALF_W-1:0] eff_addr,
   input  logic [1:0]        mask_sel,
   input  logic [1:0]        act_sel,
   input  logic [1:0]        skip_sel,
   output logic              out_valid,
   output logic [WORD_W-1:0] new_reg,
   output logic              reg_we,
   output logic              skip_out
);

   if ((WORD_W % 2) != 0 || WORD_W < 2) begin : g_bad_width
      $error("mask_test_unit: WORD_W must be even and at least 2");
   end

   logic [WORD_W-1:0] mask_w;
   logic [WORD_W-1:0] upd_w;
   logic              we_w;
   logic              skip_w;

   mtu_mask_gen #(.WORD_W(WORD_W)) u_mask (
      .addr (eff_addr),
      .mem  (mem_val),
      .sel  (msrc_e'(mask_sel)),
      .mask (mask_w)
   );

   mtu_bit_update #(.WORD_W(WORD_W)) u_upd (
      .reg_in  (reg_val),
      .mask    (mask_w),
      .act     (act_e'(act_sel)),
      .reg_out (upd_w),
      .we      (we_w)
   );

   // Test uses the unmodified register, in parallel with the update
   mtu_skip_eval #(.WORD_W(WORD_W)) u_skip (
      .reg_in (reg_val),
      .mask   (mask_w),
      .cond   (skip_e'(skip_sel)),
      .skip   (skip_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         new_reg   <= '0;
         reg_we    <= 1'b0;
         skip_out  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         reg_we    <= in_valid & we_w;
         skip_out  <= in_valid & skip_w;
         if (in_valid) begin
            new_reg <= upd_w;
         end
      end
   end

endmodule

// File: rtl/mtu_checker.sv
module mtu_checker #(
   parameter int WORD_W = 36,
   localparam int HALF_W = WORD_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [WORD_W-1:0] reg_val,
   input logic [WORD_W-1:0] mem_val,
   input logic [HALF_W-1:0] eff_addr,
   input logic [1:0]        mask_sel,
   input logic [1:0]        act_sel,
   input logic [1:0]        skip_sel,
   input logic              out_valid,
   input logic [WORD_W-1:0] new_reg,
   input logic              reg_we,
   input logic              skip_out
);

   assert_follow_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !reg_we && !skip_out && $stable(new_reg)));

   assert_keep_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && act_sel == 2'd0) |=> (!reg_we && new_reg == $past(reg_val)));

   assert_clear_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && act_sel == 2'd1 && mask_sel == 2'd2)
      |=> (reg_we && (new_reg & $past(mem_val)) == '0));

   assert_set_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && act_sel == 2'd3 && mask_sel == 2'd2)
      |=> (reg_we && (new_reg & $past(mem_val)) == $past(mem_val)));

   assert_skip_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && skip_sel[1] == 1'b0) |=> (skip_out == $past(skip_sel[0])));

   assert_skip_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && skip_sel == 2'd3 && mask_sel == 2'd2)
      |=> (skip_out == ($past(reg_val & mem_val) != '0)));

endmodule

bind mask_test_unit mtu_checker #(.WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .reg_val   (reg_val),
   .mem_val   (mem_val),
   .eff_addr  (eff_addr),
   .mask_sel  (mask_sel),
   .act_sel   (act_sel),
   .skip_sel  (skip_sel),
   .out_valid (out_valid),
   .new_reg   (new_reg),
   .reg_we    (reg_we),
   .skip_out  (skip_out)
);

// File: tb/mask_test_unit_tb.sv
module mask_test_unit_tb;

   localparam int W = 36;
   localparam int H = W / 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] reg_val = '0;
   logic [W-1:0] mem_val = '0;
   logic [H-1:0] eff_addr = '0;
   logic [1:0]   mask_sel = '0;
   logic [1:0]   act_sel = '0;
   logic [1:0]   skip_sel = '0;
   logic         out_valid;
   logic [W-1:0] new_reg;
   logic         reg_we;
   logic         skip_out;

   int checks = 0;
   int fails = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   mask_test_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .reg_val(reg_val), .mem_val(mem_val), .eff_addr(eff_addr),
      .mask_sel(mask_sel), .act_sel(act_sel), .skip_sel(skip_sel),
      .out_valid(out_valid), .new_reg(new_reg), .reg_we(reg_we), .skip_out(skip_out)
   );

   function automatic logic [W-1:0] ref_mask(input logic [1:0] s, input logic [H-1:0] a,
                                             input logic [W-1:0] m);
      case (s)
         2'd0:    return {{H{1'b0}}, a};
         2'd1:    return {a, {H{1'b0}}};
         2'd2:    return m;
         default: return {m[H-1:0], m[W-1:H]};
      endcase
   endfunction

   function automatic logic [W-1:0] ref_reg(input logic [1:0] act, input logic [W-1:0] r,
                                            input logic [W-1:0] k);
      case (act)
         2'd0:    return r;
         2'd1:    return r & ~k;
         2'd2:    return r ^ k;
         default: return r | k;
      endcase
   endfunction

   function automatic logic ref_skip(input logic [1:0] c, input logic [W-1:0] r,
                                     input logic [W-1:0] k);
      case (c)
         2'd0:    return 1'b0;
         2'd1:    return 1'b1;
         2'd2:    return (r & k) == '0;
         default: return (r & k) != '0;
      endcase
   endfunction

   function automatic string act_tag(input logic [1:0] act);
      case (act)
         2'd0:    return "R3";
         2'd1:    return "R4";
         2'd2:    return "R5";
         default: return "R6";
      endcase
   endfunction

   function automatic string skip_tag(input logic [1:0] c);
      return c[1] ? "R8" : "R7";
   endfunction

   task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Drive at a falling edge, sample at the next falling edge
   task automatic run_op(input logic [W-1:0] r, input logic [W-1:0] m, input logic [H-1:0] a,
                         input logic [1:0] ms, input logic [1:0] ac, input logic [1:0] sk,
                         input string msk_tag);
      logic [W-1:0] k;
      k = ref_mask(ms, a, m);
      reg_val = r; mem_val = m; eff_addr = a;
      mask_sel = ms; act_sel = ac; skip_sel = sk; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R9", W'(out_valid), W'(1'b1));
      check(msk_tag.len() > 0 ? msk_tag : act_tag(ac), new_reg, ref_reg(ac, r, k));
      check(act_tag(ac), W'(reg_we), W'(ac != 2'd0));
      check(skip_tag(sk), W'(skip_out), W'(ref_skip(sk, r, k)));
   endtask

   task automatic idle_check();
      logic [W-1:0] held;
      held = new_reg;
      in_valid = 1'b0;
      reg_val = ~reg_val;
      @(negedge clk);
      check("R10", W'(out_valid), '0);
      check("R10", W'(reg_we), '0);
      check("R10", W'(skip_out), '0);
      check("R10", new_reg, held);
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd20180715));
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", W'(out_valid), '0);
      check("R1", W'(reg_we), '0);
      check("R1", W'(skip_out), '0);
      check("R1", new_reg, '0);
      rst_n = 1'b1;

      // R2: mask sources, act=flip from zero exposes the mask directly
      run_op('0, 36'h0_0000_0001, 18'h2_0003, 2'd0, 2'd2, 2'd0, "R2");
      run_op('0, 36'h0_0000_0001, 18'h2_0003, 2'd1, 2'd2, 2'd0, "R2");
      run_op('0, 36'h8_0001_2345, 18'h0_0000, 2'd2, 2'd2, 2'd0, "R2");
      run_op('0, 36'h8_0001_2345, 18'h0_0000, 2'd3, 2'd2, 2'd0, "R2");
      run_op('0, 36'h0_0000_0001, 18'h0_0000, 2'd3, 2'd2, 2'd0, "R2");

      // R8: skip uses register before update
      run_op({W{1'b1}}, 36'hF_0000_000F, '0, 2'd2, 2'd1, 2'd3, "");
      run_op({W{1'b1}}, 36'hF_0000_000F, '0, 2'd2, 2'd1, 2'd2, "");
      run_op('0, 36'h0_0F0F_0000, '0, 2'd2, 2'd3, 2'd2, "");
      run_op('0, 36'h0_0F0F_0000, '0, 2'd2, 2'd3, 2'd3, "");
      run_op(36'h5_5555_5555, '0, 18'h0_0002, 2'd0, 2'd2, 2'd2, "");
      run_op(36'h5_5555_5555, '0, 18'h0_0001, 2'd0, 2'd2, 2'd3, "");
      run_op(36'hA_AAAA_AAAA, '0, 18'h3_FFFF, 2'd1, 2'd0, 2'd1, "");
      run_op(36'hA_AAAA_AAAA, '0, 18'h3_FFFF, 2'd1, 2'd0, 2'd0, "");
      idle_check();

      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] r;
         logic [W-1:0] m;
         r = {$urandom(), $urandom()};
         m = {$urandom(), $urandom()};
         run_op(r, m, H'($urandom()), 2'($urandom()), 2'($urandom()), 2'($urandom()), "");
         if (($urandom() % 4) == 0) idle_check();
      end

      // back-to-back requests with no gap
      for (int s = 0; s < 64; s++) begin
         run_op(36'h1_2345_6789, 36'h9_8765_4321, 18'h1_5A5A,
                2'(s), 2'(s >> 2), 2'(s >> 4), "");
      end
      idle_check();

      done = 1'b1;
      finish_run();
   end

endmodule